// File: doc/BRIEF.md
# Local Interrupt Request and Service Controller

This block sits beside a processor core and keeps the per-vector bookkeeping for up to 256 interrupt vectors. A delivery interface posts vectors into a pending-request bit array. A trigger-mode bit array records whether each vector was level or edge triggered, and an in-service bit array records the vectors the core has taken but not yet retired. A vector's priority class is its upper four bits, and higher vector numbers win. The block raises `intr` when the best pending vector's class is strictly above the current processor class. That class is the larger of the programmed task-priority class and the class of the highest in-service vector.

The core takes a vector with a one-cycle `ack_req` pulse. A two-state handshake machine answers with `ack_valid` and the vector on the following cycle. It has two states, ACK_IDLE and ACK_GRANT. The transition *take* (ACK_IDLE to ACK_GRANT) fires on `ack_req`. The transition *release* (ACK_GRANT to ACK_IDLE) fires unconditionally one cycle later, and any `ack_req` that arrives while in ACK_GRANT is ignored. On *take* the winning vector moves from pending to in-service. If no vector qualifies, the spurious vector is handed over and all state is left unchanged.

Software uses a small register port. Address 0 holds the task priority. A write to address 1 retires the highest in-service vector; if that vector was level triggered, a broadcast pulse carrying its number follows. Address 2 is the error status register, and address 3 holds the spurious vector in bits 7:0 with the software-enable flag in bit 8. The error bits are 0x80 for an undefined register address and 0x40 for an illegal received vector. They collect in a hidden sticky accumulator, and a write to address 2 copies the accumulator into the readable register.

Top module: `lirq_ctrl`

## Requirements
- R1: After reset, intr, ack_valid and eoi_bcast_valid are 0, and reads return 0 for task priority (addr 0), 0 for error status (addr 2) and 0x0FF for addr 3 (spurious vector 0xFF, enable bit 8 clear).
- R2: A delivery with a vector of 0x10 or more sets that vector's pending bit, and records level (dlv_level=1) or edge (dlv_level=0) in its trigger-mode bit.
- R3: A delivered vector below 0x10 is not made pending and sets error bit 0x40 in the accumulator.
- R4: intr is 1 exactly when software-enable is set, some vector is pending, and the top pending vector's bits 7:4 exceed the larger of task-priority bits 7:4 and the top in-service vector's bits 7:4 (0 when none is in service).
- R5: An ack_req taken in ACK_IDLE gives ack_valid high for exactly one cycle on the next cycle, with ack_vector set to the top pending vector. That vector's pending bit clears and its in-service bit sets.
- R6: An ack_req taken while no vector qualifies under R4 returns the spurious vector (addr 3 bits 7:0) and changes neither the pending nor the in-service bits.
- R7: A write to addr 1 clears the highest set in-service bit. With no bit in service, the write has no effect.
- R8: When the vector retired under R7 is level triggered, eoi_bcast_valid is 1 for one cycle, in the cycle after the write, with eoi_bcast_vector equal to that vector. An edge-triggered retirement gives no pulse.
- R9: A write to addr 2 copies the accumulated error bits into the readable error register and clears the accumulator. The bits stay sticky until that write. A write to an address from 4 to 7 sets error bit 0x80.
- R10: While software-enable (addr 3 bit 8) is 0, intr stays 0 whatever is pending.
- R11: When a legal delivery and a granted acknowledge fall in the same cycle on the same vector, the vector moves to in-service and stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery strobe |
| dlv_vector | input | 8 | Delivered vector |
| dlv_level | input | 1 | 1 = level triggered, 0 = edge |
| ack_req | input | 1 | Processor acknowledge request pulse |
| intr | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Acknowledge response strobe |
| ack_vector | output | 8 | Granted or spurious vector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| eoi_bcast_valid | output | 1 | EOI broadcast pulse for level vectors |
| eoi_bcast_vector | output | 8 | Vector carried by the broadcast |

## Verification
Delivery and acknowledge can act on the same pending bit in one cycle: the delivery sets the bit while the grant clears it. The bench first makes a vector pending. It then drives a delivery of that same vector in the very cycle it raises `ack_req`. The grant must return the vector, and after the vector is retired a second acknowledge must return it again, which proves the pending bit survived the collision.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    typedef enum logic {
        ACK_IDLE  = 1'b0,
        ACK_GRANT = 1'b1
    } lirq_ack_e;

    localparam logic [2:0] RA_TPR = 3'd0;
    localparam logic [2:0] RA_EOI = 3'd1;
    localparam logic [2:0] RA_ESR = 3'd2;
    localparam logic [2:0] RA_SVR = 3'd3;

    localparam int ERRB_BAD_ADDR  = 7;
    localparam int ERRB_RX_BADVEC = 6;

endpackage

// File: rtl/lirq_bitvec.sv
module lirq_bitvec #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  bits
);

    // One flop per vector; a set aimed at a bit wins over a clear of it.
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits[g] <= 1'b0;
            end else if (set_en && set_idx == IW'(g)) begin
                bits[g] <= 1'b1;
            end else if (clr_en && clr_idx == IW'(g)) begin
                bits[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lirq_prio_enc.sv
module lirq_prio_enc #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Highest set bit wins: later iterations overwrite earlier ones.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lirq_regfile.sv
module lirq_regfile
    import lirq_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_bad_vec,
    output logic [VEC_W-1:0]  tpr,
    output logic [VEC_W-1:0]  spur_vec,
    output logic              sw_en,
    output logic              eoi_wr,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(RA_SVR);

    logic [VEC_W-1:0] tpr_q;
    logic [VEC_W:0]   svr_q;
    logic [7:0]       esr_q;
    logic [7:0]       acc_q;
    logic [7:0]       new_err;
    logic             wr_tpr, wr_esr, wr_svr, wr_bad;

    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:VEC_W+1];

    assign wr_tpr = wr && (addr == ADDR_W'(RA_TPR));
    assign eoi_wr = wr && (addr == ADDR_W'(RA_EOI));
    assign wr_esr = wr && (addr == ADDR_W'(RA_ESR));
    assign wr_svr = wr && (addr == ADDR_W'(RA_SVR));
    assign wr_bad = wr && (addr > LAST_ADDR);

    always_comb begin
        new_err = 8'h00;
        new_err[ERRB_BAD_ADDR]  = wr_bad;
        new_err[ERRB_RX_BADVEC] = rx_bad_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= '0;
            svr_q <= {1'b0, {VEC_W{1'b1}}};
            esr_q <= 8'h00;
            acc_q <= 8'h00;
        end else begin
            if (wr_tpr) tpr_q <= wdata[VEC_W-1:0];
            if (wr_svr) svr_q <= wdata[VEC_W:0];
            if (wr_esr) begin
                esr_q <= acc_q;
                acc_q <= new_err;
            end else begin
                acc_q <= acc_q | new_err;
            end
        end
    end

    assign tpr      = tpr_q;
    assign spur_vec = svr_q[VEC_W-1:0];
    assign sw_en    = svr_q[VEC_W];

    always_comb begin
        unique case (addr)
            ADDR_W'(RA_TPR): rdata = DATA_W'(tpr_q);
            ADDR_W'(RA_ESR): rdata = DATA_W'(esr_q);
            ADDR_W'(RA_SVR): rdata = DATA_W'(svr_q);
            default:         rdata = '0;
        endcase
    end

    p_bad_addr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bad && !wr_esr) |=> acc_q[ERRB_BAD_ADDR]);

    p_esr_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_esr |=> (esr_q == $past(acc_q)));

    p_rx_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q[ERRB_RX_BADVEC] && !wr_esr) |=> acc_q[ERRB_RX_BADVEC]);

endmodule

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
    import lirq_pkg::*;
#(
    parameter int NUM_VEC   = 256,
    parameter int CLS_W     = 4,
    parameter int MIN_LEGAL = 16,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32,
    localparam int VEC_W    = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dlv_valid,
    input  logic [VEC_W-1:0]  dlv_vector,
    input  logic              dlv_level,
    input  logic              ack_req,
    output logic              intr,
    output logic              ack_valid,
    output logic [VEC_W-1:0]  ack_vector,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              eoi_bcast_valid,
    output logic [VEC_W-1:0]  eoi_bcast_vector
);

    logic [NUM_VEC-1:0] irr_bits, isr_bits, tmr_bits;
    logic               irr_any, isr_any;
    logic [VEC_W-1:0]   irr_top, isr_top;
    logic [VEC_W-1:0]   tpr, spur_vec;
    logic               sw_en, eoi_wr;
    logic               dlv_legal, dlv_post, rx_bad;
    logic [CLS_W-1:0]   irr_cls, isr_cls, tpr_cls, ppr_cls;
    logic               qualify, ack_take, grant_hit, eoi_fire;
    lirq_ack_e          state_q, state_d;

    logic unused_tpr;
    assign unused_tpr = ^tpr[VEC_W-CLS_W-1:0];

    assign dlv_legal = dlv_vector >= VEC_W'(MIN_LEGAL);
    assign dlv_post  = dlv_valid && dlv_legal;
    assign rx_bad    = dlv_valid && !dlv_legal;

    lirq_regfile #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rx_bad_vec(rx_bad), .tpr(tpr), .spur_vec(spur_vec), .sw_en(sw_en),
        .eoi_wr(eoi_wr), .rdata(reg_rdata)
    );

    lirq_prio_enc #(.N(NUM_VEC), .IW(VEC_W)) u_irr_enc (
        .req(irr_bits), .any(irr_any), .idx(irr_top));
    lirq_prio_enc #(.N(NUM_VEC), .IW(VEC_W)) u_isr_enc (
        .req(isr_bits), .any(isr_any), .idx(isr_top));

    // Priority decision
    assign irr_cls  = irr_top[VEC_W-1 -: CLS_W];
    assign isr_cls  = isr_any ? isr_top[VEC_W-1 -: CLS_W] : '0;
    assign tpr_cls  = tpr[VEC_W-1 -: CLS_W];
    assign ppr_cls  = (tpr_cls > isr_cls) ? tpr_cls : isr_cls;
    assign qualify  = sw_en && irr_any && (irr_cls > ppr_cls);

    assign ack_take  = (state_q == ACK_IDLE) && ack_req;
    assign grant_hit = ack_take && qualify;
    assign eoi_fire  = eoi_wr && isr_any;

    // Pending: delivery set wins over grant clear (same-vector collision)
    lirq_bitvec #(.N(NUM_VEC), .IW(VEC_W)) u_irr (
        .clk(clk), .rst_n(rst_n),
        .set_en(dlv_post), .set_idx(dlv_vector),
        .clr_en(grant_hit), .clr_idx(irr_top), .bits(irr_bits));

    // In service: grant sets, EOI clears the top bit
    lirq_bitvec #(.N(NUM_VEC), .IW(VEC_W)) u_isr (
        .clk(clk), .rst_n(rst_n),
        .set_en(grant_hit), .set_idx(irr_top),
        .clr_en(eoi_fire), .clr_idx(isr_top), .bits(isr_bits));

    // Trigger mode: written on each legal delivery
    lirq_bitvec #(.N(NUM_VEC), .IW(VEC_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .set_en(dlv_post && dlv_level), .set_idx(dlv_vector),
        .clr_en(dlv_post && !dlv_level), .clr_idx(dlv_vector), .bits(tmr_bits));

    // Handshake state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:  if (ack_req) state_d = ACK_GRANT;
            ACK_GRANT: state_d = ACK_IDLE;
            default:   state_d = ACK_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vector       <= '0;
            eoi_bcast_valid  <= 1'b0;
            eoi_bcast_vector <= '0;
        end else begin
            if (ack_take) ack_vector <= grant_hit ? irr_top : spur_vec;
            eoi_bcast_valid <= eoi_fire && tmr_bits[isr_top];
            if (eoi_fire) eoi_bcast_vector <= isr_top;
        end
    end

    assign ack_valid = (state_q == ACK_GRANT);
    assign intr      = qualify;

    p_intr_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> sw_en);

    p_intr_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> (irr_bits != '0));

    p_ack_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    p_grant_moves_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_hit |=> (isr_bits[$past(irr_top)] && ack_vector == $past(irr_top)));

    p_spurious_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !qualify && !dlv_valid && !eoi_wr)
            |=> ($stable(irr_bits) && $stable(isr_bits) && ack_vector == $past(spur_vec)));

    p_illegal_not_posted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bad && !grant_hit) |=> $stable(irr_bits));

    p_delivery_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_post |=> irr_bits[$past(dlv_vector)]);

    p_bcast_after_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast_valid |-> $past(eoi_fire));

endmodule

// File: tb/lirq_ctrl_tb.sv
`timescale 1ns/100ps
module lirq_ctrl_tb;

    typedef enum logic [2:0] {
        OP_DLV  = 3'd0,   // a=vector, d[0]=level
        OP_WR   = 3'd1,   // a=addr,   d=data
        OP_ACK  = 3'd2,   // d=expected ack_vector
        OP_INTR = 3'd3,   // d=expected intr
        OP_RD   = 3'd4    // a=addr,   d=expected rdata
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [7:0]  a;
        logic [31:0] d;
        logic [7:0]  req;
    } step_t;

    function automatic step_t mk(op_e op, logic [7:0] a, logic [31:0] d, logic [7:0] req);
        mk.op = op; mk.a = a; mk.d = d; mk.req = req;
    endfunction

    localparam int NSTEPS = 49;
    localparam step_t STEPS [NSTEPS] = '{
        mk(OP_WR,   8'd3,  32'h1FF, 8'd10),  // R10 enable, spurious FF
        mk(OP_DLV,  8'h35, 32'd0,   8'd2),   // R2 edge
        mk(OP_INTR, 8'd0,  32'd1,   8'd4),   // R4
        mk(OP_DLV,  8'h52, 32'd1,   8'd2),   // R2 level
        mk(OP_INTR, 8'd0,  32'd1,   8'd4),
        mk(OP_WR,   8'd0,  32'h60,  8'd4),   // R4 TPR masks class 5
        mk(OP_INTR, 8'd0,  32'd0,   8'd4),
        mk(OP_WR,   8'd0,  32'h40,  8'd4),
        mk(OP_INTR, 8'd0,  32'd1,   8'd4),
        mk(OP_ACK,  8'd0,  32'h52,  8'd5),   // R5
        mk(OP_INTR, 8'd0,  32'd0,   8'd4),   // ISR class 5 blocks 0x35
        mk(OP_ACK,  8'd0,  32'hFF,  8'd6),   // R6
        mk(OP_WR,   8'd0,  32'h00,  8'd4),
        mk(OP_INTR, 8'd0,  32'd0,   8'd4),
        mk(OP_DLV,  8'h61, 32'd0,   8'd2),
        mk(OP_INTR, 8'd0,  32'd1,   8'd4),
        mk(OP_ACK,  8'd0,  32'h61,  8'd5),
        mk(OP_WR,   8'd1,  32'd0,   8'd7),   // R7 retire 0x61
        mk(OP_INTR, 8'd0,  32'd0,   8'd7),
        mk(OP_WR,   8'd1,  32'd0,   8'd7),   // retire 0x52
        mk(OP_INTR, 8'd0,  32'd1,   8'd7),
        mk(OP_ACK,  8'd0,  32'h35,  8'd5),
        mk(OP_WR,   8'd1,  32'd0,   8'd7),
        mk(OP_INTR, 8'd0,  32'd0,   8'd7),
        mk(OP_WR,   8'd1,  32'd0,   8'd7),   // R7 EOI with nothing in service
        mk(OP_ACK,  8'd0,  32'hFF,  8'd7),
        mk(OP_DLV,  8'h05, 32'd0,   8'd3),   // R3 illegal
        mk(OP_INTR, 8'd0,  32'd0,   8'd3),
        mk(OP_RD,   8'd2,  32'h00,  8'd9),   // R9 not visible yet
        mk(OP_WR,   8'd2,  32'd0,   8'd9),
        mk(OP_RD,   8'd2,  32'h40,  8'd3),
        mk(OP_WR,   8'd2,  32'd0,   8'd9),
        mk(OP_RD,   8'd2,  32'h00,  8'd9),
        mk(OP_WR,   8'd5,  32'd0,   8'd9),   // R9 bad address
        mk(OP_WR,   8'd2,  32'd0,   8'd9),
        mk(OP_RD,   8'd2,  32'h80,  8'd9),
        mk(OP_DLV,  8'h3A, 32'd0,   8'd4),
        mk(OP_DLV,  8'h3C, 32'd0,   8'd4),
        mk(OP_ACK,  8'd0,  32'h3C,  8'd5),
        mk(OP_INTR, 8'd0,  32'd0,   8'd4),   // same class not strictly above
        mk(OP_ACK,  8'd0,  32'hFF,  8'd6),
        mk(OP_WR,   8'd1,  32'd0,   8'd7),
        mk(OP_ACK,  8'd0,  32'h3A,  8'd5),
        mk(OP_WR,   8'd1,  32'd0,   8'd7),
        mk(OP_WR,   8'd3,  32'h0AB, 8'd10),  // R10 disable, spurious AB
        mk(OP_DLV,  8'h80, 32'd0,   8'd10),
        mk(OP_INTR, 8'd0,  32'd0,   8'd10),
        mk(OP_ACK,  8'd0,  32'hAB,  8'd6),
        mk(OP_RD,   8'd3,  32'h0AB, 8'd10)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dlv_valid = 1'b0;
    logic [7:0]  dlv_vector = '0;
    logic        dlv_level = 1'b0;
    logic        ack_req = 1'b0;
    logic        intr, ack_valid, eoi_bcast_valid;
    logic [7:0]  ack_vector, eoi_bcast_vector;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lirq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_level(dlv_level),
        .ack_req(ack_req), .intr(intr), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vector(eoi_bcast_vector)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic deliver(logic [7:0] v, logic lvl);
        @(negedge clk);
        dlv_valid = 1'b1; dlv_vector = v; dlv_level = lvl;
        @(negedge clk);
        dlv_valid = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ack(string req, logic [7:0] exp);
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        chk({req, " ack_valid"}, 32'(ack_valid), 32'd1);
        chk({req, " ack_vector"}, 32'(ack_vector), 32'(exp));
    endtask

    task automatic rd(string req, logic [2:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk({req, " rdata"}, reg_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 intr", 32'(intr), 32'd0);
        chk("R1 ack_valid", 32'(ack_valid), 32'd0);
        chk("R1 bcast", 32'(eoi_bcast_valid), 32'd0);
        rd("R1", 3'd0, 32'h0);
        rd("R1", 3'd2, 32'h0);
        rd("R1", 3'd3, 32'h0FF);

        for (int i = 0; i < NSTEPS; i++) begin
            string tag;
            tag = $sformatf("R%0d step %0d", STEPS[i].req, i);
            unique case (STEPS[i].op)
                OP_DLV:  deliver(STEPS[i].a, STEPS[i].d[0]);
                OP_WR:   wr(STEPS[i].a[2:0], STEPS[i].d);
                OP_ACK:  ack(tag, STEPS[i].d[7:0]);
                OP_INTR: begin
                    @(negedge clk);
                    chk({tag, " intr"}, 32'(intr), STEPS[i].d);
                end
                OP_RD:   rd(tag, STEPS[i].a[2:0], STEPS[i].d);
                default: ;
            endcase
        end

        // R10 re-enable releases the held 0x80
        wr(3'd3, 32'h1AB);
        @(negedge clk);
        chk("R10 intr after enable", 32'(intr), 32'd1);
        ack("R5", 8'h80);
        wr(3'd1, 32'd0);

        // R8 level vector broadcasts on EOI
        deliver(8'h70, 1'b1);
        ack("R8", 8'h70);
        wr(3'd1, 32'd0);
        chk("R8 bcast valid", 32'(eoi_bcast_valid), 32'd1);
        chk("R8 bcast vector", 32'(eoi_bcast_vector), 32'h70);
        @(negedge clk);
        chk("R8 bcast one cycle", 32'(eoi_bcast_valid), 32'd0);

        // R8 edge vector: no broadcast
        deliver(8'h71, 1'b0);
        ack("R8", 8'h71);
        wr(3'd1, 32'd0);
        chk("R8 edge no bcast", 32'(eoi_bcast_valid), 32'd0);

        // R11 delivery and grant of the same vector in one cycle
        deliver(8'h90, 1'b0);
        @(negedge clk);
        ack_req = 1'b1;
        dlv_valid = 1'b1; dlv_vector = 8'h90; dlv_level = 1'b0;
        @(negedge clk);
        ack_req = 1'b0; dlv_valid = 1'b0;
        chk("R11 ack_vector", 32'(ack_vector), 32'h90);
        wr(3'd1, 32'd0);
        @(negedge clk);
        chk("R11 still pending intr", 32'(intr), 32'd1);
        ack("R11", 8'h90);
        wr(3'd1, 32'd0);
        @(negedge clk);
        chk("R11 drained intr", 32'(intr), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule